// File: doc/BRIEF.md
# Double-Word Helper Execute Unit

This block is the execute stage of a small word-oriented processor. Each cycle it may be handed one instruction: a five-bit opcode, the values already read for the two source registers and for the destination register, and the low nine bits of the instruction, which hold any immediate field. One clock later it presents the value to be written back and a flag that says whether a write should happen. Register file, fetch, branch resolution and condition-code logic live elsewhere.

Beyond plain arithmetic, logic and shifts, the unit keeps a little state between instructions. A carry flag records the carry-out of the most recent carry-producing operation, so that software can chain word-sized additions into wider ones. It can also read the flag back as a number. A pair of negate instructions lets a double-word value be negated one word at a time: the low-word negate remembers whether its operand was zero, and the high-word negate that follows it directly adds the propagated one only in that case. Two single-bit shifts that pull a bit across from a second register let a double-word value be shifted by one in either direction.

Top module: `mwx_exec`

## Requirements
- R1: After reset `wr_en_o` is 0, `result_o` is 0 and the carry flag is 0, so a GCAR (opcode 10111) issued first returns 0.
- R2: Opcode 00101 returns `rs + rt`, 00110 returns `rs - rt` and 00111 returns `rs` plus `imm_i[4:0]` sign-extended, all modulo 2^W.
- R3: Opcode 01001 returns `rs` AND the sign-extended `imm_i[4:0]`; opcode 01011 returns `imm_i[8:0]` sign-extended.
- R4: Opcode 01100 returns `rs` shifted left and 01101 returns `rs` shifted right logically, by the unsigned amount `imm_i[3:0]`.
- R5: Opcode 01110 returns `rs >> 1`; 01111 returns `rt >> 1` with `rs[0]` in bit W-1; 10010 returns `rs << 1` with `rt[W-1]` in bit 0.
- R6: The carry flag takes the carry-out of 00101, 00111 and 10110, the no-borrow bit of 00110 (1 when `rs >= rt` unsigned), and for 10100 the value 1 exactly when `rd` is 0; every other opcode and every idle cycle leaves it unchanged. GCAR (10111) returns it as 0 or 1.
- R7: Opcode 10110 returns `rs + carry`.
- R8: Opcode 10100 returns the two's complement of `rd`, `~rd + 1`.
- R9: Opcode 10101 returns `~rd + 1` when the instruction issued immediately before it was 10100 with a zero `rd`, and `~rd` in every other case (including an earlier 10100 separated by another issued instruction).
- R10: Results and `wr_en_o` appear on the clock edge after the issuing edge; a cycle with `issue_i` low gives `wr_en_o` 0, keeps `result_o`, and does not count as an instruction for R9.
- R11: Opcodes 00000-00100, 01000, 01010, 10000, 10001, 10011 and 11000-11111 give `wr_en_o` 0 and leave `result_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 5 | Instruction opcode |
| imm_i | input | 9 | Low nine instruction bits (immediates and shift amount) |
| rs_val_i | input | W | First source register value |
| rt_val_i | input | W | Second source register value |
| rd_val_i | input | W | Current destination register value |
| result_o | output | W | Value to write back, registered |
| wr_en_o | output | 1 | Write-back enable, registered |

## Verification
The assertions assume that `opcode_i`, `imm_i` and the three register values are stable and known whenever `issue_i` is high, and that the decision of which instruction counts as "previous" is made only by issued cycles. The stimulus drives every input from a single place half a cycle away from the sampling edge, mixes idle cycles in at random, and draws opcodes over all 32 codes so that the unlisted ones are exercised as well. Directed sequences place low-word negates of zero and non-zero operands directly before, and one instruction before, the high-word negate, and chain additions through the carry flag.

// File: rtl/mwx_pkg.sv
package mwx_pkg;

    localparam logic [4:0] OP_ADD   = 5'b00101;
    localparam logic [4:0] OP_SUB   = 5'b00110;
    localparam logic [4:0] OP_ADDI  = 5'b00111;
    localparam logic [4:0] OP_ANDI  = 5'b01001;
    localparam logic [4:0] OP_CONST = 5'b01011;
    localparam logic [4:0] OP_SLL   = 5'b01100;
    localparam logic [4:0] OP_SRL   = 5'b01101;
    localparam logic [4:0] OP_SDRH  = 5'b01110;
    localparam logic [4:0] OP_SDRL  = 5'b01111;
    localparam logic [4:0] OP_SDL   = 5'b10010;
    localparam logic [4:0] OP_TCS   = 5'b10100;
    localparam logic [4:0] OP_TCDH  = 5'b10101;
    localparam logic [4:0] OP_ADDC  = 5'b10110;
    localparam logic [4:0] OP_GCAR  = 5'b10111;

    // Shifter variants
    typedef enum logic [2:0] {
        SH_LEFT_N  = 3'd0,
        SH_RIGHT_N = 3'd1,
        SH_HALVE   = 3'd2,
        SH_JOIN_R  = 3'd3,
        SH_JOIN_L  = 3'd4
    } shift_mode_e;

    // Which value feeds the write-back mux
    typedef enum logic [2:0] {
        RS_NONE  = 3'd0,
        RS_ADDER = 3'd1,
        RS_AND   = 3'd2,
        RS_IMM   = 3'd3,
        RS_SHIFT = 3'd4,
        RS_CARRY = 3'd5
    } res_src_e;

    // Operand selection for the shared adder
    typedef enum logic [2:0] {
        AD_RS_RT   = 3'd0,
        AD_RS_NRT  = 3'd1,
        AD_RS_IMM  = 3'd2,
        AD_RS_CY   = 3'd3,
        AD_NRD_ONE = 3'd4,
        AD_NRD_HI  = 3'd5
    } add_sel_e;

endpackage

// File: rtl/mwx_decode.sv
module mwx_decode
    import mwx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [4:0]   opcode_i,
    input  logic [8:0]   imm_i,
    output logic [W-1:0] imm5_x_o,
    output logic [W-1:0] imm9_x_o,
    output logic [3:0]   shamt_o,
    output res_src_e     res_src_o,
    output add_sel_e     add_sel_o,
    output shift_mode_e  shift_mode_o,
    output logic         sets_carry_o,
    output logic         is_low_neg_o
);

    localparam int IMM5_W = 5;
    localparam int IMM9_W = 9;

    assign imm5_x_o = {{(W-IMM5_W){imm_i[IMM5_W-1]}}, imm_i[IMM5_W-1:0]};
    assign imm9_x_o = {{(W-IMM9_W){imm_i[IMM9_W-1]}}, imm_i[IMM9_W-1:0]};
    assign shamt_o  = imm_i[3:0];

    always_comb begin
        res_src_o    = RS_NONE;
        add_sel_o    = AD_RS_RT;
        shift_mode_o = SH_LEFT_N;
        sets_carry_o = 1'b0;
        is_low_neg_o = 1'b0;
        unique case (opcode_i)
            OP_ADD: begin
                res_src_o    = RS_ADDER;
                add_sel_o    = AD_RS_RT;
                sets_carry_o = 1'b1;
            end
            OP_SUB: begin
                res_src_o    = RS_ADDER;
                add_sel_o    = AD_RS_NRT;
                sets_carry_o = 1'b1;
            end
            OP_ADDI: begin
                res_src_o    = RS_ADDER;
                add_sel_o    = AD_RS_IMM;
                sets_carry_o = 1'b1;
            end
            OP_ADDC: begin
                res_src_o    = RS_ADDER;
                add_sel_o    = AD_RS_CY;
                sets_carry_o = 1'b1;
            end
            OP_TCS: begin
                res_src_o    = RS_ADDER;
                add_sel_o    = AD_NRD_ONE;
                sets_carry_o = 1'b1;
                is_low_neg_o = 1'b1;
            end
            OP_TCDH: begin
                res_src_o = RS_ADDER;
                add_sel_o = AD_NRD_HI;
            end
            OP_ANDI:  res_src_o = RS_AND;
            OP_CONST: res_src_o = RS_IMM;
            OP_SLL: begin
                res_src_o    = RS_SHIFT;
                shift_mode_o = SH_LEFT_N;
            end
            OP_SRL: begin
                res_src_o    = RS_SHIFT;
                shift_mode_o = SH_RIGHT_N;
            end
            OP_SDRH: begin
                res_src_o    = RS_SHIFT;
                shift_mode_o = SH_HALVE;
            end
            OP_SDRL: begin
                res_src_o    = RS_SHIFT;
                shift_mode_o = SH_JOIN_R;
            end
            OP_SDL: begin
                res_src_o    = RS_SHIFT;
                shift_mode_o = SH_JOIN_L;
            end
            OP_GCAR:  res_src_o = RS_CARRY;
            default:  res_src_o = RS_NONE;
        endcase
    end

endmodule

// File: rtl/mwx_adder.sv
module mwx_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] wide;

    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, b_i} + {{(SUM_W-1){1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
    end

endmodule

// File: rtl/mwx_shift.sv
module mwx_shift
    import mwx_pkg::*;
#(
    parameter int W = 16
) (
    input  shift_mode_e  mode_i,
    input  logic [W-1:0] src_i,
    input  logic [W-2:0] other_hi_i,
    input  logic [3:0]   amt_i,
    output logic [W-1:0] out_o
);

    always_comb begin
        unique case (mode_i)
            SH_LEFT_N:  out_o = src_i << amt_i;
            SH_RIGHT_N: out_o = src_i >> amt_i;
            SH_HALVE:   out_o = {1'b0, src_i[W-1:1]};
            SH_JOIN_R:  out_o = {src_i[0], other_hi_i};
            SH_JOIN_L:  out_o = {src_i[W-2:0], other_hi_i[W-2]};
            default:    out_o = src_i;
        endcase
    end

endmodule

// File: rtl/mwx_exec.sv
module mwx_exec
    import mwx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  logic [4:0]   opcode_i,
    input  logic [8:0]   imm_i,
    input  logic [W-1:0] rs_val_i,
    input  logic [W-1:0] rt_val_i,
    input  logic [W-1:0] rd_val_i,
    output logic [W-1:0] result_o,
    output logic         wr_en_o
);

    typedef struct packed {
        logic [W-1:0] result;
        logic         wr;
        logic         carry;
        logic         prev_low_neg;
        logic         low_was_zero;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] imm5_x, imm9_x;
    logic [3:0]   shamt;
    res_src_e     res_src;
    add_sel_e     add_sel;
    shift_mode_e  shift_mode;
    logic         sets_carry;
    logic         is_low_neg;

    logic [W-1:0] add_a, add_b, add_sum;
    logic         add_cin, add_cout;
    logic [W-1:0] shift_out;
    logic [W-1:0] res_val;

    mwx_decode #(.W(W)) u_dec (
        .opcode_i     (opcode_i),
        .imm_i        (imm_i),
        .imm5_x_o     (imm5_x),
        .imm9_x_o     (imm9_x),
        .shamt_o      (shamt),
        .res_src_o    (res_src),
        .add_sel_o    (add_sel),
        .shift_mode_o (shift_mode),
        .sets_carry_o (sets_carry),
        .is_low_neg_o (is_low_neg)
    );

    // Adder operand selection: one adder serves all sums and negations
    always_comb begin
        add_a   = rs_val_i;
        add_b   = rt_val_i;
        add_cin = 1'b0;
        unique case (add_sel)
            AD_RS_RT: begin
                add_a = rs_val_i;
                add_b = rt_val_i;
            end
            AD_RS_NRT: begin
                add_a   = rs_val_i;
                add_b   = ~rt_val_i;
                add_cin = 1'b1;
            end
            AD_RS_IMM: begin
                add_a = rs_val_i;
                add_b = imm5_x;
            end
            AD_RS_CY: begin
                add_a   = rs_val_i;
                add_b   = '0;
                add_cin = st_q.carry;
            end
            AD_NRD_ONE: begin
                add_a   = ~rd_val_i;
                add_b   = '0;
                add_cin = 1'b1;
            end
            AD_NRD_HI: begin
                add_a   = ~rd_val_i;
                add_b   = '0;
                add_cin = st_q.prev_low_neg & st_q.low_was_zero;
            end
            default: begin
                add_a = rs_val_i;
                add_b = rt_val_i;
            end
        endcase
    end

    mwx_adder #(.W(W)) u_add (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .cout_o (add_cout)
    );

    mwx_shift #(.W(W)) u_shf (
        .mode_i     (shift_mode),
        .src_i      (rs_val_i),
        .other_hi_i (rt_val_i[W-1:1]),
        .amt_i      (shamt),
        .out_o      (shift_out)
    );

    // Write-back value selection
    always_comb begin
        unique case (res_src)
            RS_ADDER: res_val = add_sum;
            RS_AND:   res_val = rs_val_i & imm5_x;
            RS_IMM:   res_val = imm9_x;
            RS_SHIFT: res_val = shift_out;
            RS_CARRY: res_val = {{(W-1){1'b0}}, st_q.carry};
            default:  res_val = '0;
        endcase
    end

    // Next-state computation
    always_comb begin
        st_d    = st_q;
        st_d.wr = 1'b0;
        if (issue_i) begin
            st_d.prev_low_neg = is_low_neg;
            if (is_low_neg) begin
                st_d.low_was_zero = (rd_val_i == '0);
            end
            if (sets_carry) begin
                st_d.carry = add_cout;
            end
            if (res_src != RS_NONE) begin
                st_d.result = res_val;
                st_d.wr     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign wr_en_o  = st_q.wr;

endmodule

// File: rtl/mwx_exec_chk.sv
module mwx_exec_chk
    import mwx_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue_i,
    input logic [4:0]   opcode_i,
    input logic [W-1:0] rs_val_i,
    input logic [W-1:0] rt_val_i,
    input logic [W-1:0] rd_val_i,
    input logic [W-1:0] result_o,
    input logic         wr_en_o,
    input logic         carry_q
);

    logic op_no_result;
    logic op_carry_src;

    always_comb begin
        op_no_result = (opcode_i <= 5'b00100) || (opcode_i == 5'b01000) ||
                       (opcode_i == 5'b01010) || (opcode_i == 5'b10000) ||
                       (opcode_i == 5'b10001) || (opcode_i == 5'b10011) ||
                       (opcode_i >= 5'b11000);
        op_carry_src = (opcode_i == OP_ADD) || (opcode_i == OP_SUB) ||
                       (opcode_i == OP_ADDI) || (opcode_i == OP_ADDC) ||
                       (opcode_i == OP_TCS);
    end

    // R10: idle cycle gives no write and keeps the result
    p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_i |=> (!wr_en_o && $stable(result_o)));

    // R11: opcodes without a register result
    p_no_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && op_no_result) |=> (!wr_en_o && $stable(result_o)));

    // R6: carry held by non-carry opcodes and idle cycles
    p_carry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_i || !op_carry_src) |=> $stable(carry_q));

    // R6: read-back carry is 0 or 1
    p_gcar_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == OP_GCAR) |=> (wr_en_o && result_o[W-1:1] == '0));

    // R2: subtraction
    p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == OP_SUB) |=>
            (wr_en_o && result_o == W'($past(rs_val_i) - $past(rt_val_i))));

    // R8: low-word negate
    p_tcs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == OP_TCS) |=>
            (wr_en_o && result_o == W'(~$past(rd_val_i) + 1'b1)));

    // R9: high-word negate is ~rd or ~rd + 1
    p_tcdh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && opcode_i == OP_TCDH) |=>
            (wr_en_o && (result_o == ~$past(rd_val_i) ||
                         result_o == W'(~$past(rd_val_i) + 1'b1))));

endmodule

bind mwx_exec mwx_exec_chk #(.W(W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue_i  (issue_i),
    .opcode_i (opcode_i),
    .rs_val_i (rs_val_i),
    .rt_val_i (rt_val_i),
    .rd_val_i (rd_val_i),
    .result_o (result_o),
    .wr_en_o  (wr_en_o),
    .carry_q  (st_q.carry)
);

// File: tb/test_mwx_exec.sv
module test_mwx_exec;

    localparam int W = 16;
    localparam int M = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_i = 1'b0;
    logic [4:0]   opcode_i = '0;
    logic [8:0]   imm_i = '0;
    logic [W-1:0] rs_val_i = '0;
    logic [W-1:0] rt_val_i = '0;
    logic [W-1:0] rd_val_i = '0;
    logic [W-1:0] result_o;
    logic         wr_en_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_res = 0, m_wr = 0, m_carry = 0, m_prev_tcs = 0, m_lz = 0;
    string m_tag = "R1";

    always #5 clk = ~clk;

    mwx_exec #(.W(W)) i_mwx_exec (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
        .imm_i(imm_i), .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
        .rd_val_i(rd_val_i), .result_o(result_o), .wr_en_o(wr_en_o)
    );

    function automatic string tag_of(input int op);
        case (op)
            5, 6, 7:    return "R2";
            9, 11:      return "R3";
            12, 13:     return "R4";
            14, 15, 18: return "R5";
            23:         return "R6";
            22:         return "R7";
            20:         return "R8";
            21:         return "R9";
            default:    return "R11";
        endcase
    endfunction

    function automatic int sx(input int v, input int bits);
        int s = v & ((1 << bits) - 1);
        if (s >= (1 << (bits - 1))) s = s - (1 << bits);
        return s & M;
    endfunction

    // Behavioural model: one instruction (or idle) per call
    task automatic model(input bit iss, input int op, input int imm,
                         input int rs, input int rt, input int rd);
        int r;
        int c;
        bit w;
        r = m_res; c = m_carry; w = 1'b0;
        if (!iss) begin
            m_wr = 0; m_tag = "R10";
            return;
        end
        m_tag = tag_of(op);
        w = 1'b1;
        case (op)
            5:  begin r = rs + rt; c = (r >> W) & 1; end
            6:  begin r = rs - rt; c = (rs >= rt) ? 1 : 0; end
            7:  begin r = rs + sx(imm, 5); c = (r >> W) & 1; end
            9:  r = rs & sx(imm, 5);
            11: r = sx(imm, 9);
            12: r = rs << (imm & 15);
            13: r = rs >> (imm & 15);
            14: r = rs >> 1;
            15: r = ((rs & 1) << (W - 1)) | (rt >> 1);
            18: r = (rs << 1) | ((rt >> (W - 1)) & 1);
            20: begin r = (~rd & M) + 1; c = (rd == 0) ? 1 : 0; end
            21: r = (~rd & M) + ((m_prev_tcs != 0 && m_lz != 0) ? 1 : 0);
            22: begin r = rs + m_carry; c = (r >> W) & 1; end
            23: r = m_carry;
            default: w = 1'b0;
        endcase
        if (op == 20) m_lz = (rd == 0) ? 1 : 0;
        m_prev_tcs = (op == 20) ? 1 : 0;
        m_carry = c;
        if (w) m_res = r & M;
        m_wr = w;
    endtask

    task automatic check(input string tag);
        n_cmp++;
        if (wr_en_o !== m_wr[0] || result_o !== m_res[W-1:0]) begin
            n_bad++;
            $display("FAIL %s: wr=%0b result=%h expected wr=%0b result=%h",
                     tag, wr_en_o, result_o, m_wr[0], m_res[W-1:0]);
        end
    endtask

    // Drive at falling edge, let one rising edge pass, compare at next falling edge
    task automatic step(input bit iss, input int op, input int imm,
                        input int rs, input int rt, input int rd);
        issue_i  = iss;
        opcode_i = op[4:0];
        imm_i    = imm[8:0];
        rs_val_i = rs[W-1:0];
        rt_val_i = rt[W-1:0];
        rd_val_i = rd[W-1:0];
        model(iss, op, imm, rs & M, rt & M, rd & M);
        @(negedge clk);
        check(m_tag);
    endtask

    function automatic int rval();
        case ($urandom_range(0, 5))
            0: return 0;
            1: return M;
            2: return 1 << (W - 1);
            default: return $urandom() & M;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        // R1 / R6: carry reads 0 after reset
        step(1, 23, 0, 0, 0, 0);

        // R2 / R6 / R7: double-word add via carry chain
        step(1, 5, 0, 16'hFFF0, 16'h0020, 0);
        step(1, 22, 0, 16'h0003, 0, 0);
        step(1, 23, 0, 0, 0, 0);
        step(1, 6, 0, 16'h0005, 16'h0009, 0);   // borrow -> carry 0
        step(1, 23, 0, 0, 0, 0);
        step(1, 6, 0, 16'h0009, 16'h0009, 0);   // no borrow -> carry 1
        step(1, 23, 0, 0, 0, 0);
        step(1, 7, 5'h1F, 16'h0001, 0, 0);      // add -1
        step(1, 23, 0, 0, 0, 0);

        // R8 / R9: double-word negate, zero and non-zero low words
        step(1, 20, 0, 0, 0, 16'h0000);
        step(1, 21, 0, 0, 0, 16'h1234);
        step(1, 20, 0, 0, 0, 16'h0001);
        step(1, 21, 0, 0, 0, 16'h1234);
        // R9: separated by another instruction -> no increment
        step(1, 20, 0, 0, 0, 16'h0000);
        step(1, 11, 9'h005, 0, 0, 0);
        step(1, 21, 0, 0, 0, 16'h00FF);
        // R10: idle cycle between still breaks the pair only if issued; idle is not counted
        step(1, 20, 0, 0, 0, 16'h0000);
        step(0, 0, 0, 0, 0, 0);
        step(1, 21, 0, 0, 0, 16'h00FF);
        // R9: TCDH without any preceding TCS
        step(1, 21, 0, 0, 0, 16'h8000);

        // R3 / R4 / R5 directed corners
        step(1, 9, 9'h010, 16'hABCD, 0, 0);
        step(1, 11, 9'h100, 0, 0, 0);
        step(1, 12, 9'h00F, 16'h0003, 0, 0);
        step(1, 13, 9'h00F, 16'h8000, 0, 0);
        step(1, 14, 0, 16'h8001, 0, 0);
        step(1, 15, 0, 16'h0001, 16'h0003, 0);
        step(1, 18, 0, 16'h4000, 16'h8000, 0);
        // R11: non-result opcodes hold result
        step(1, 0, 0, 16'h1111, 16'h2222, 0);
        step(1, 19, 0, 16'h1111, 16'h2222, 0);
        step(1, 31, 0, 16'h1111, 16'h2222, 0);

        // Random mix over all opcodes with idle cycles (R2..R11)
        for (int i = 0; i < 4000; i++) begin
            int op;
            op = $urandom_range(0, 31);
            if ($urandom_range(0, 3) == 0) op = 20 + $urandom_range(0, 3);
            step($urandom_range(0, 4) != 0, op, $urandom_range(0, 511),
                 rval(), rval(), rval());
        end
        issue_i = 1'b0;

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule